// File: doc/BRIEF.md
# Cipher Engine Register Front-End

This block is the software-facing side of a block-cipher accelerator. A 32-bit, word-only register bus reaches a control register, a status register, an interrupt flag and an interrupt enable. The same bus reaches an eight-word key store and a single data port. Writes to the data port collect a 128-bit input block. Reads from the data port return the 128-bit result. The cipher datapath sits outside the block. It is reached through a start/done handshake that carries the block, the selected key, a key-length code and a decrypt flag.

The fourth word written to the data port launches an operation by itself. A launch can also be requested through the control register. The control register selects the key length (128, 192 or 256 bits) and one of three operations: encrypt, decrypt with the current key, or decrypt with the key and length captured at the most recent encrypt or decrypt-with-current-key launch. When the core answers, four result words become pending, a completion flag is raised, and the interrupt line follows that flag gated by its enable.

Top module: `cxe_regfront`

## Requirements
- R1: After reset, CTRL (0x000) reads 0, STAT (0x004) reads 0x5, IFLAG (0x008) reads 0, irq is low and no launch occurs.
- R2: The n-th word (n = 0..3) written to the data port (0x010) since the input became empty appears on core_block bits [32n+31:32n] at the next launch.
- R3: Writing the fourth word launches an operation with no start command: core_start is a one-cycle pulse in the cycle after that write, and the input count returns to empty.
- R4: A write to 0x400+4i stores key bits [32i+31:32i]. CTRL bits [7:6] = 0 presents key bits [127:0] with klen code 0, = 1 presents bits [191:0] with code 1, and = 2 or 3 presents all 256 bits with code 2. Key bits above the selected length are zero on core_key.
- R5: CTRL bits [9:8] = 0 encrypts (core_decrypt 0) and = 1 decrypts (core_decrypt 1), both with the current key. Both modes save that key and klen code. A value of 2 or 3 decrypts with the saved key and code.
- R6: A core_done accepted while an operation is outstanding makes four result words pending, sets STAT bit 3 and sets IFLAG bit 0.
- R7: A data-port read with words pending returns result bits [32k+31:32k] for k = 0,1,2,3 in that order, and the first such read clears IFLAG bit 0. A read with nothing pending returns 0 and changes nothing.
- R8: Writing CTRL with bit 2 set empties the input count, and with bit 3 set empties the result count. Neither bit reads back.
- R9: Once CTRL bit 0 has been written as 1, it stays 1 until reset.
- R10: Writing CTRL with bit 1 set launches with the key-length and mode fields of that same write and with the current input buffer. Bit 1 reads back 0. Start requests made while an operation is outstanding are dropped.
- R11: STAT bit 0 means input empty and bit 1 means input full (always 0, since the count wraps at a full block). Bit 2 means result empty and bit 3 means four result words pending.
- R12: irq equals IFLAG bit 0 AND IEN bit 0. IEN is read/write at 0x00C.
- R13: IFLAG is read-only and the key store is write-only (reads return 0). Misaligned offsets, unmapped offsets and offsets at or above 0xC00 are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Interrupt request |
| core_start | output | 1 | One-cycle launch pulse to the cipher core |
| core_decrypt | output | 1 | 1 = decrypt |
| core_klen | output | 2 | Key length code: 0 = 128, 1 = 192, 2 = 256 |
| core_key | output | 256 | Key presented to the core, zero above the length |
| core_block | output | 128 | Input block |
| core_done | input | 1 | Core completion pulse |
| core_result | input | 128 | Result block, valid with core_done |

## Verification
The assertions assume two things about the environment. The bus makes at most one access per cycle. The cipher core raises core_done only for a launch it has received, never while idle. The bench keeps to both. Its core model answers each core_start exactly once after a fixed latency, and each bus task issues a single access followed by an idle cycle. The second start request in the busy test is timed to arrive before the model answers, so the drop is exercised without breaking the done-only-when-busy assumption.

// File: rtl/cxe_pkg.sv
package cxe_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] A_CTRL  = 12'h000;
  localparam logic [REG_AW-1:0] A_STAT  = 12'h004;
  localparam logic [REG_AW-1:0] A_IFLAG = 12'h008;
  localparam logic [REG_AW-1:0] A_IEN   = 12'h00C;
  localparam logic [REG_AW-1:0] A_FIFO  = 12'h010;
  localparam logic [REG_AW-1:0] A_KEY   = 12'h400;
  localparam logic [REG_AW-1:0] A_LIMIT = 12'hC00;

  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_START  = 1;
  localparam int unsigned CB_IFLUSH = 2;
  localparam int unsigned CB_OFLUSH = 3;
  localparam int unsigned CB_KSZ    = 6;
  localparam int unsigned CB_TYPE   = 8;

  typedef enum logic [1:0] {
    KL_128 = 2'd0,
    KL_192 = 2'd1,
    KL_256 = 2'd2
  } klen_e;

  typedef struct packed {
    logic key;
    logic fifo;
    logic ien;
    logic iflag;
    logic stat;
    logic ctrl;
  } sel_t;
endpackage

// File: rtl/cxe_decode.sv
module cxe_decode import cxe_pkg::*; #(
  parameter int unsigned KEY_WORDS = 8,
  parameter int unsigned KIW       = $clog2(KEY_WORDS)
) (
  input  logic              valid,
  input  logic              write,
  input  logic [REG_AW-1:0] addr,
  output sel_t              wsel,
  output sel_t              rsel,
  output logic [KIW-1:0]    kidx
);
  localparam logic [REG_AW-1:0] KEY_TOP = A_KEY + REG_AW'(4 * KEY_WORDS);

  logic ok;
  sel_t hit;

  always_comb begin
    ok        = valid && (addr[1:0] == 2'b00) && (addr < A_LIMIT);
    hit       = '0;
    hit.ctrl  = (addr == A_CTRL);
    hit.stat  = (addr == A_STAT);
    hit.iflag = (addr == A_IFLAG);
    hit.ien   = (addr == A_IEN);
    hit.fifo  = (addr == A_FIFO);
    hit.key   = (addr >= A_KEY) && (addr < KEY_TOP);
    wsel      = (ok && write)  ? hit : '0;
    rsel      = (ok && !write) ? hit : '0;
  end

  // key window base is word aligned, so the word index is the low address bits
  assign kidx = addr[2 +: KIW];
endmodule

// File: rtl/cxe_keystore.sv
module cxe_keystore import cxe_pkg::*; #(
  parameter int unsigned DW        = 32,
  parameter int unsigned KEY_WORDS = 8,
  parameter int unsigned KIW       = $clog2(KEY_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [KIW-1:0]          idx,
  input  logic [DW-1:0]           wdata,
  input  logic [1:0]              ksz,
  output logic [KEY_WORDS*DW-1:0] key_out,
  output klen_e                   klen
);
  localparam int unsigned W128 = 128 / DW;
  localparam int unsigned W192 = 192 / DW;

  logic [DW-1:0] kq [KEY_WORDS];
  logic [KIW:0]  used;

  always_comb begin
    case (ksz)
      2'd0:    begin used = (KIW+1)'(W128);      klen = KL_128; end
      2'd1:    begin used = (KIW+1)'(W192);      klen = KL_192; end
      default: begin used = (KIW+1)'(KEY_WORDS); klen = KL_256; end
    endcase
  end

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    logic wen;
    assign wen = we && (idx == KIW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   kq[g] <= '0;
      else if (wen) kq[g] <= wdata;
    end

    assign key_out[g*DW +: DW] = ((KIW+1)'(g) < used) ? kq[g] : '0;
  end
endmodule

// File: rtl/cxe_launch.sv
module cxe_launch import cxe_pkg::*; #(
  parameter int unsigned KEY_BITS = 256,
  parameter int unsigned BLK_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [1:0]          mode,
  input  logic [KEY_BITS-1:0] cur_key,
  input  klen_e               cur_klen,
  input  logic [BLK_BITS-1:0] blk,
  input  logic                core_done,
  output logic                core_start,
  output logic                core_decrypt,
  output logic [1:0]          core_klen,
  output logic [KEY_BITS-1:0] core_key,
  output logic [BLK_BITS-1:0] core_block,
  output logic                done_acc
);
  logic                busy_q, busy_d;
  logic                start_q, start_d;
  logic                dec_q, dec_d;
  klen_e               klen_q, klen_d;
  logic [KEY_BITS-1:0] key_q, key_d;
  logic [BLK_BITS-1:0] blk_q, blk_d;
  logic [KEY_BITS-1:0] skey_q, skey_d;
  klen_e               sklen_q, sklen_d;
  logic                go, use_saved;

  always_comb begin
    go        = req && !busy_q;
    use_saved = mode[1];
    done_acc  = core_done && busy_q;
    start_d   = go;
    busy_d    = busy_q;
    dec_d     = dec_q;
    klen_d    = klen_q;
    key_d     = key_q;
    blk_d     = blk_q;
    skey_d    = skey_q;
    sklen_d   = sklen_q;
    if (done_acc) busy_d = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      dec_d  = (mode != 2'd0);
      blk_d  = blk;
      if (use_saved) begin
        key_d  = skey_q;
        klen_d = sklen_q;
      end else begin
        key_d   = cur_key;
        klen_d  = cur_klen;
        skey_d  = cur_key;
        sklen_d = cur_klen;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      dec_q   <= 1'b0;
      klen_q  <= KL_128;
      key_q   <= '0;
      blk_q   <= '0;
      skey_q  <= '0;
      sklen_q <= KL_128;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      dec_q   <= dec_d;
      klen_q  <= klen_d;
      key_q   <= key_d;
      blk_q   <= blk_d;
      skey_q  <= skey_d;
      sklen_q <= sklen_d;
    end
  end

  assign core_start   = start_q;
  assign core_decrypt = dec_q;
  assign core_klen    = klen_q;
  assign core_key     = key_q;
  assign core_block   = blk_q;

  // environment: the core only answers an outstanding launch
  assert_done_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> busy_q);

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
endmodule

// File: rtl/cxe_regfront.sv
module cxe_regfront import cxe_pkg::*; #(
  parameter int unsigned DW        = 32,
  parameter int unsigned BLK_WORDS = 4,
  parameter int unsigned KEY_WORDS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [11:0]             bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  output logic                    irq,
  output logic                    core_start,
  output logic                    core_decrypt,
  output logic [1:0]              core_klen,
  output logic [KEY_WORDS*DW-1:0] core_key,
  output logic [BLK_WORDS*DW-1:0] core_block,
  input  logic                    core_done,
  input  logic [BLK_WORDS*DW-1:0] core_result
);
  localparam int unsigned BLK_BITS = DW * BLK_WORDS;
  localparam int unsigned KEY_BITS = DW * KEY_WORDS;
  localparam int unsigned ICW      = $clog2(BLK_WORDS);
  localparam int unsigned RCW      = $clog2(BLK_WORDS + 1);
  localparam int unsigned KIW      = $clog2(KEY_WORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rstn_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rstn_s = rs_q[1];

  sel_t           wsel, rsel;
  logic [KIW-1:0] kidx;

  cxe_decode #(.KEY_WORDS(KEY_WORDS), .KIW(KIW)) u_decode (
    .valid (bus_valid),
    .write (bus_write),
    .addr  (bus_addr),
    .wsel  (wsel),
    .rsel  (rsel),
    .kidx  (kidx)
  );

  logic                en_q, en_d;
  logic [1:0]          ksz_q, ksz_d;
  logic [1:0]          typ_q, typ_d;
  logic                ien_q, ien_d;
  logic                done_q, done_d;
  logic [ICW-1:0]      icnt_q, icnt_d;
  logic [RCW-1:0]      rcnt_q, rcnt_d;
  logic [BLK_BITS-1:0] din_q, din_d;
  logic [BLK_BITS-1:0] res_q, res_d;
  logic [DW-1:0]       rdata_q, rdata_d;

  logic [1:0]          eff_ksz, eff_typ;
  logic                launch_req;
  logic [KEY_BITS-1:0] cur_key;
  klen_e               cur_klen;
  logic                done_acc;
  logic [DW-1:0]       ctrl_rd, stat_rd, fifo_word;
  logic                wr_ro;

  cxe_keystore #(.DW(DW), .KEY_WORDS(KEY_WORDS), .KIW(KIW)) u_keys (
    .clk     (clk),
    .rst_n   (rstn_s),
    .we      (wsel.key),
    .idx     (kidx),
    .wdata   (bus_wdata),
    .ksz     (eff_ksz),
    .key_out (cur_key),
    .klen    (cur_klen)
  );

  cxe_launch #(.KEY_BITS(KEY_BITS), .BLK_BITS(BLK_BITS)) u_launch (
    .clk          (clk),
    .rst_n        (rstn_s),
    .req          (launch_req),
    .mode         (eff_typ),
    .cur_key      (cur_key),
    .cur_klen     (cur_klen),
    .blk          (din_d),
    .core_done    (core_done),
    .core_start   (core_start),
    .core_decrypt (core_decrypt),
    .core_klen    (core_klen),
    .core_key     (core_key),
    .core_block   (core_block),
    .done_acc     (done_acc)
  );

  // register read views
  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[CB_EN]       = en_q;
    ctrl_rd[CB_KSZ +: 2] = ksz_q;
    ctrl_rd[CB_TYPE +: 2] = typ_q;
    stat_rd              = '0;
    stat_rd[0]           = (icnt_q == '0);
    stat_rd[1]           = 1'b0;
    stat_rd[2]           = (rcnt_q == '0);
    stat_rd[3]           = (rcnt_q == RCW'(BLK_WORDS));
    fifo_word            = '0;
    for (int k = 0; k < BLK_WORDS; k++) begin
      if (rcnt_q == RCW'(BLK_WORDS - k)) fifo_word = res_q[k*DW +: DW];
    end
  end

  assign wr_ro = wsel.stat | wsel.iflag;

  // next state
  always_comb begin
    en_d       = en_q;
    ksz_d      = ksz_q;
    typ_d      = typ_q;
    ien_d      = ien_q;
    done_d     = done_q;
    icnt_d     = icnt_q;
    rcnt_d     = rcnt_q;
    din_d      = din_q;
    res_d      = res_q;
    rdata_d    = rdata_q;
    eff_ksz    = ksz_q;
    eff_typ    = typ_q;
    launch_req = 1'b0;

    if (wsel.ctrl) begin
      en_d    = en_q | bus_wdata[CB_EN];
      ksz_d   = bus_wdata[CB_KSZ +: 2];
      typ_d   = bus_wdata[CB_TYPE +: 2];
      eff_ksz = ksz_d;
      eff_typ = typ_d;
      if (bus_wdata[CB_IFLUSH]) icnt_d = '0;
      if (bus_wdata[CB_OFLUSH]) rcnt_d = '0;
      if (bus_wdata[CB_START])  launch_req = 1'b1;
    end

    if (wsel.ien) ien_d = bus_wdata[0];

    if (wsel.fifo) begin
      for (int k = 0; k < BLK_WORDS; k++) begin
        if (icnt_q == ICW'(k)) din_d[k*DW +: DW] = bus_wdata;
      end
      if (icnt_q == ICW'(BLK_WORDS - 1)) begin
        icnt_d     = '0;
        launch_req = 1'b1;
      end else begin
        icnt_d = icnt_q + 1'b1;
      end
    end

    if (rsel.fifo && (rcnt_q != '0)) begin
      rcnt_d = rcnt_q - 1'b1;
      done_d = 1'b0;
    end

    if (bus_valid && !bus_write) begin
      rdata_d = '0;
      if (rsel.ctrl)  rdata_d = ctrl_rd;
      if (rsel.stat)  rdata_d = stat_rd;
      if (rsel.iflag) rdata_d = {{(DW-1){1'b0}}, done_q};
      if (rsel.ien)   rdata_d = {{(DW-1){1'b0}}, ien_q};
      if (rsel.fifo)  rdata_d = fifo_word;
      if (rsel.key)   rdata_d = '0;
    end

    if (done_acc) begin
      rcnt_d = RCW'(BLK_WORDS);
      res_d  = core_result;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      en_q    <= 1'b0;
      ksz_q   <= '0;
      typ_q   <= '0;
      ien_q   <= 1'b0;
      done_q  <= 1'b0;
      icnt_q  <= '0;
      rcnt_q  <= '0;
      din_q   <= '0;
      res_q   <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      ksz_q   <= ksz_d;
      typ_q   <= typ_d;
      ien_q   <= ien_d;
      done_q  <= done_d;
      icnt_q  <= icnt_d;
      rcnt_q  <= rcnt_d;
      din_q   <= din_d;
      res_q   <= res_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = done_q & ien_q;

  assert_done_fills_R6: assert property (@(posedge clk) disable iff (!rstn_s)
    done_acc |=> (rcnt_q == RCW'(BLK_WORDS)) && done_q);

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rstn_s)
    (rsel.fifo && (rcnt_q == '0) && !done_acc) |=> (rcnt_q == '0));

  assert_enable_sticky_R9: assert property (@(posedge clk) disable iff (!rstn_s)
    en_q |=> en_q);

  assert_ro_write_R13: assert property (@(posedge clk) disable iff (!rstn_s)
    (wr_ro && !done_acc) |=> $stable(done_q));
endmodule

// File: tb/cxe_regfront_tb.sv
`timescale 1ns/1ps
module cxe_regfront_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_valid, bus_write;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         irq, core_start, core_decrypt, core_done;
  logic [1:0]   core_klen;
  logic [255:0] core_key;
  logic [127:0] core_block, core_result;

  always #2.5 clk = ~clk;

  cxe_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .core_start(core_start), .core_decrypt(core_decrypt), .core_klen(core_klen),
    .core_key(core_key), .core_block(core_block), .core_done(core_done),
    .core_result(core_result)
  );

  int nchk = 0, nfail = 0, nstart = 0;
  logic [127:0] cap_blk;
  logic [255:0] cap_key;
  logic [1:0]   cap_klen;
  logic         cap_dec;

  function automatic logic [127:0] fm(input logic [127:0] b, input logic [255:0] k,
                                      input logic [1:0] kl, input logic d);
    return b ^ k[127:0] ^ k[255:128] ^ {126'd0, kl} ^ {128{d}};
  endfunction

  function automatic logic [255:0] kmask(input logic [255:0] k, input int ks);
    if (ks == 0) return {128'd0, k[127:0]};
    if (ks == 1) return {64'd0, k[191:0]};
    return k;
  endfunction

  function automatic logic [1:0] kcode(input int ks);
    return (ks == 0) ? 2'd0 : (ks == 1) ? 2'd1 : 2'd2;
  endfunction

  // cipher core model: fixed latency, one answer per launch
  initial begin
    core_done = 1'b0;
    core_result = '0;
    forever begin
      @(negedge clk);
      if (core_start === 1'b1) begin
        cap_blk = core_block; cap_key = core_key; cap_klen = core_klen; cap_dec = core_decrypt;
        repeat (3) @(negedge clk);
        core_result = fm(cap_blk, cap_key, cap_klen, cap_dec);
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (core_start === 1'b1) nstart++;
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, {224'd0, d}, {224'd0, exp});
  endtask

  task automatic load_key(input logic [255:0] k);
    for (int i = 0; i < 8; i++) wr(12'h400 + 12'(4*i), k[32*i +: 32]);
  endtask

  task automatic push_block(input logic [127:0] b);
    for (int n = 0; n < 4; n++) wr(12'h010, b[32*n +: 32]);
  endtask

  // read the four result words, checking order and flag clearing
  task automatic drain(input string tag, input logic [127:0] exp);
    for (int k = 0; k < 4; k++) begin
      rd_chk({tag, " R7 word"}, 12'h010, exp[32*k +: 32]);
      if (k == 0) begin
        rd_chk("R7 flag cleared by read", 12'h008, 32'd0);
        chk("R12 irq after clear", {255'd0, irq}, 256'd0);
      end
    end
    rd_chk("R7 empty read", 12'h010, 32'd0);
    rd_chk("R11 stat after drain", 12'h004, 32'h5);
  endtask

  logic done_run = 1'b0;
  initial begin
    #500000;
    if (!done_run) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [255:0] keyA, keyB;
    logic [127:0] blk, blkY;
    int s0;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd_chk("R1 ctrl reset", 12'h000, 32'd0);
    rd_chk("R1 stat reset", 12'h004, 32'h5);
    rd_chk("R1 iflag reset", 12'h008, 32'd0);
    chk("R1 irq reset", {255'd0, irq}, 256'd0);
    chk("R1 no launch", 256'(nstart), 256'd0);

    wr(12'h000, 32'h1);
    rd_chk("R9 enable set", 12'h000, 32'h1);
    wr(12'h000, 32'h0);
    rd_chk("R9 enable sticky", 12'h000, 32'h1);

    wr(12'h00C, 32'h1);
    rd_chk("R12 ien readback", 12'h00C, 32'h1);

    for (int i = 0; i < 8; i++) keyA[32*i +: 32] = 32'hA500_0000 ^ (32'(i) * 32'h0103_0507);
    load_key(keyA);

    for (int ks = 0; ks < 4; ks++) begin
      for (int md = 0; md < 2; md++) begin
        wr(12'h000, (32'(md) << 8) | (32'(ks) << 6) | 32'h1);
        for (int n = 0; n < 4; n++)
          blk[32*n +: 32] = 32'h1357_9BDF ^ (32'(n) * 32'h0101_0101) ^ (32'(ks*2+md) << 20);
        s0 = nstart;
        for (int n = 0; n < 3; n++) wr(12'h010, blk[32*n +: 32]);
        rd_chk("R11 stat partial block", 12'h004, 32'h4);
        chk("R3 no launch before fourth word", 256'(nstart), 256'(s0));
        wr(12'h010, blk[127:96]);
        repeat (8) @(negedge clk);
        chk("R3 auto launch", 256'(nstart), 256'(s0 + 1));
        chk("R2 block order", {128'd0, cap_blk}, {128'd0, blk});
        chk("R4 key select", cap_key, kmask(keyA, ks));
        chk("R4 klen code", {254'd0, cap_klen}, {254'd0, kcode(ks)});
        chk("R5 decrypt flag", {255'd0, cap_dec}, {255'd0, md != 0});
        rd_chk("R6 stat full", 12'h004, 32'h9);
        rd_chk("R6 iflag set", 12'h008, 32'h1);
        chk("R12 irq raised", {255'd0, irq}, {255'd0, 1'b1});
        drain("sweep", fm(blk, kmask(keyA, ks), kcode(ks), md != 0));
      end
    end

    // saved key: last launch was ks=3, mode 1
    keyB = ~keyA;
    load_key(keyB);
    wr(12'h000, (32'd2 << 8) | 32'h1);
    blk = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    push_block(blk);
    repeat (8) @(negedge clk);
    chk("R5 saved key used", cap_key, kmask(keyA, 3));
    chk("R5 saved klen used", {254'd0, cap_klen}, 256'd2);
    chk("R5 saved mode decrypts", {255'd0, cap_dec}, {255'd0, 1'b1});
    drain("saved", fm(blk, kmask(keyA, 3), 2'd2, 1'b1));

    wr(12'h000, (32'd0 << 8) | (32'd1 << 6) | 32'h1);
    push_block(blk ^ 128'h55);
    repeat (8) @(negedge clk);
    chk("R5 mode0 current key", cap_key, kmask(keyB, 1));
    drain("refresh", fm(blk ^ 128'h55, kmask(keyB, 1), 2'd1, 1'b0));

    wr(12'h000, (32'd3 << 8) | 32'h1);
    push_block(blk ^ 128'hAA);
    repeat (8) @(negedge clk);
    chk("R5 saved key refreshed", cap_key, kmask(keyB, 1));
    chk("R5 saved klen refreshed", {254'd0, cap_klen}, 256'd1);
    drain("mode3", fm(blk ^ 128'hAA, kmask(keyB, 1), 2'd1, 1'b1));

    // flushes
    wr(12'h010, 32'h1111_1111);
    wr(12'h010, 32'h2222_2222);
    rd_chk("R11 stat input held", 12'h004, 32'h4);
    wr(12'h000, 32'h4 | 32'h1);
    rd_chk("R8 input flushed", 12'h004, 32'h5);
    rd_chk("R8 flush bit not kept", 12'h000, 32'h1);
    s0 = nstart;
    blkY = 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1234_5678;
    for (int n = 0; n < 3; n++) wr(12'h010, blkY[32*n +: 32]);
    chk("R8 count restarted", 256'(nstart), 256'(s0));
    wr(12'h010, blkY[127:96]);
    repeat (8) @(negedge clk);
    chk("R8 launch after four", 256'(nstart), 256'(s0 + 1));
    chk("R2 block after flush", {128'd0, cap_blk}, {128'd0, blkY});
    wr(12'h000, 32'h8 | 32'h1);
    rd_chk("R8 output flushed", 12'h004, 32'h5);
    rd_chk("R8 flushed read zero", 12'h010, 32'd0);

    // explicit start, second request while busy dropped
    s0 = nstart;
    wr(12'h000, (32'd2 << 6) | 32'h2 | 32'h1);
    wr(12'h000, (32'd2 << 6) | 32'h2 | 32'h1);
    repeat (8) @(negedge clk);
    chk("R10 single launch while busy", 256'(nstart), 256'(s0 + 1));
    chk("R10 uses written ksz", {254'd0, cap_klen}, 256'd2);
    chk("R10 uses held block", {128'd0, cap_blk}, {128'd0, blkY});
    chk("R10 key", cap_key, kmask(keyB, 2));
    rd_chk("R10 start not kept", 12'h000, 32'h81);
    drain("start", fm(blkY, kmask(keyB, 2), 2'd2, 1'b0));

    // address map edges
    wr(12'h020, 32'hFFFF_FFFF);
    rd_chk("R13 unmapped reads zero", 12'h020, 32'd0);
    wr(12'h001, 32'h0);
    rd_chk("R13 misaligned ignored", 12'h000, 32'h81);
    wr(12'h00D, 32'h0);
    rd_chk("R13 misaligned ien ignored", 12'h00C, 32'h1);
    wr(12'hC00, 32'h1);
    rd_chk("R13 beyond window", 12'hC00, 32'd0);
    rd_chk("R13 key write-only", 12'h400, 32'd0);
    wr(12'h008, 32'h1);
    rd_chk("R13 iflag read-only", 12'h008, 32'd0);
    chk("R12 irq stays low", {255'd0, irq}, 256'd0);

    done_run = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule